// File: doc/BRIEF.md
# Prioritising Interrupt Controller with Channel Map and Nesting Threshold

This block gathers a parameterised set of system interrupt lines (64 by default). Each line is conditioned by its own polarity and detection-mode bit. Edge-mode lines latch a pending bit on the chosen transition. Level-mode lines report the active level each cycle. A pending line counts only if its own enable bit is set. Each source carries a byte-wide channel number. Channel 0 is the most urgent and higher numbers are less urgent.

Two host lines leave the block. The fast line serves channels 0 and 1. The normal line serves channels 2 and up. A host line rises only when three things are true: the global enable is on, that host's own enable is on, and a qualifying channel lies strictly below the current nesting threshold. Software reaches every control through a word-addressed write port and a combinational read port. Per-source and per-host enables use index-set and index-clear registers. A readable register reports the number of the most urgent pending source.

Top module: `ictl_top`

## Requirements
- R1: After reset all source enables, host enables and the global enable are 0. All status bits and channel fields are 0, every polarity bit is 1, every mode bit is 0 (level) and the threshold reads 32. Both host lines are low and the source-index register (addr 0x07) reads 32'hFFFFFFFF.
- R2: Polarity word w sits at addr 0x10+w and mode word w at addr 0x18+w. Bit k of each belongs to source 32w+k. Mode 1 selects edge detection: the status bit sets on a rising input (polarity 1) or a falling input (polarity 0), compared against the input of the previous cycle. Mode 0 selects level detection: the status bit equals the active level (input equal to polarity) of the previous cycle. A clear does not remove it while the input stays active.
- R3: Writing a source number to addr 0x01 sets that source's enable, and writing it to addr 0x02 clears it. Numbers at or above the source count are ignored. Enable word w reads at addr 0x20+w.
- R4: Status word w reads at addr 0x08+w. Writing a source number to addr 0x03 clears that edge-mode status bit. Writing a word to addr 0x08+w clears every status bit whose written bit is 1.
- R5: Channel-map register r at addr 0x40+r holds the channel number of source 4r+k in bits 8k+7:8k, for k = 0..3. A channel number at or above 32 never reaches a host line and never appears in the source-index register.
- R6: Pending enabled sources on channels 0 and 1 drive the fast line. Those on channels 2 to 31 drive the normal line. The two lines are evaluated independently.
- R7: The global enable (addr 0x00, bit 0) gates both host lines. Writing 0 or 1 to addr 0x04 sets the fast or normal host enable, and writing it to addr 0x05 clears that enable.
- R8: A write to addr 0x06 with bit 31 set loads the threshold from bits 5:0. A write with bit 31 clear has no effect. Only channels numbered strictly below the threshold may drive a host line. The threshold reads back at addr 0x06.
- R9: Addr 0x07 returns the number of the pending, enabled source that has the lowest channel number. Among sources on the same channel, the lowest source number wins. It returns all ones when there is none. It ignores the global enable, host enables and threshold.
- R10: Host lines are registered. A host line rises exactly one clock after the status bit of a newly pending, enabled source sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Raw system interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_fast | output | 1 | Fast host interrupt (channels 0-1) |
| irq_norm | output | 1 | Normal host interrupt (channels 2 and up) |

## Verification
The bench walks all 64 sources through the edge path. Each source is checked for status latching, the one-clock host delay and the reported index. A design with an extra output stage, or with mis-wired enable bits, fails in that walk. Threshold edges are probed at exactly the channel number, where an off-by-one (<= instead of <) would leak the interrupt. Shared-channel ties are probed too, where a reversed scan would report the higher source. Level sources are cleared while still asserted and must stay pending. Clear words are written across word boundaries. Out-of-range indexes and channel values are written to confirm that nothing changes.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
    localparam int A_GLB     = 'h00;
    localparam int A_EN_SET  = 'h01;
    localparam int A_EN_CLR  = 'h02;
    localparam int A_ST_CLR  = 'h03;
    localparam int A_HEN_SET = 'h04;
    localparam int A_HEN_CLR = 'h05;
    localparam int A_NEST    = 'h06;
    localparam int A_PRI     = 'h07;
    localparam int A_STAT    = 'h08;
    localparam int A_POL     = 'h10;
    localparam int A_TYP     = 'h18;
    localparam int A_EN      = 'h20;
    localparam int A_MAP     = 'h40;
    localparam int FAST_CHANS = 2;
endpackage

// File: rtl/ictl_cond.sv
module ictl_cond #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] typ,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] status
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] stat;
    } cond_t;

    cond_t c_d, c_q;
    logic [NUM_SRC-1:0] active, edge_hit;

    always_comb begin
        active   = ~(src_in ^ pol);
        edge_hit = (pol & src_in & ~c_q.prev) | (~pol & ~src_in & c_q.prev);
        c_d.prev = src_in;
        c_d.stat = (~typ & active) | (typ & ((c_q.stat & ~clr) | edge_hit));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign status = c_q.stat;
endmodule

// File: rtl/ictl_prio.sv
module ictl_prio #(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CHAN = 32,
    parameter int IW       = $clog2(NUM_SRC),
    parameter int TW       = $clog2(NUM_CHAN) + 1
) (
    input  logic [NUM_SRC-1:0]      pend,
    input  logic [NUM_SRC-1:0][7:0] chmap,
    input  logic [TW-1:0]           thr,
    output logic                    pri_valid,
    output logic [IW-1:0]           pri_src,
    output logic                    fast_req,
    output logic                    norm_req
);
    localparam int CW = $clog2(NUM_CHAN);

    logic [NUM_CHAN-1:0] chan_pend;

    always_comb begin
        int best_ch;
        best_ch   = NUM_CHAN;
        pri_src   = '0;
        chan_pend = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (pend[s] && int'(chmap[s]) < NUM_CHAN) begin
                chan_pend[chmap[s][CW-1:0]] = 1'b1;
                if (int'(chmap[s]) <= best_ch) begin
                    best_ch = int'(chmap[s]);
                    pri_src = IW'(s);
                end
            end
        end
        pri_valid = best_ch < NUM_CHAN;
    end

    always_comb begin
        fast_req = 1'b0;
        norm_req = 1'b0;
        for (int c = 0; c < NUM_CHAN; c++) begin
            if (chan_pend[c] && c < int'(thr)) begin
                if (c < ictl_pkg::FAST_CHANS) fast_req = 1'b1;
                else                          norm_req = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ictl_top.sv
module ictl_top #(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CHAN = 32,
    parameter int AW       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [31:0]        rd_data,
    output logic               irq_fast,
    output logic               irq_norm
);
    import ictl_pkg::*;

    localparam int IW    = $clog2(NUM_SRC);
    localparam int TW    = $clog2(NUM_CHAN) + 1;
    localparam int NWORD = NUM_SRC / 32;
    localparam int NMAP  = NUM_SRC / 4;

    typedef struct packed {
        logic                    glb;
        logic [1:0]              hen;
        logic [NUM_SRC-1:0]      en;
        logic [NUM_SRC-1:0]      pol;
        logic [NUM_SRC-1:0]      typ;
        logic [NUM_SRC-1:0][7:0] chmap;
        logic [TW-1:0]           thr;
        logic                    fast;
        logic                    norm;
    } regs_t;

    regs_t r_d, r_q;
    logic [NUM_SRC-1:0] clr, status, pend;
    logic               pri_valid, fast_req, norm_req;
    logic [IW-1:0]      pri_src;
    logic               idx_ok;
    int                 wa, ra;

    assign wa     = int'(wr_addr);
    assign ra     = int'(rd_addr);
    assign idx_ok = wr_data < 32'(NUM_SRC);
    assign pend   = status & r_q.en;

    ictl_cond #(.NUM_SRC(NUM_SRC)) u_cond (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .pol(r_q.pol), .typ(r_q.typ), .clr(clr), .status(status)
    );

    ictl_prio #(.NUM_SRC(NUM_SRC), .NUM_CHAN(NUM_CHAN), .IW(IW), .TW(TW)) u_prio (
        .pend(pend), .chmap(r_q.chmap), .thr(r_q.thr),
        .pri_valid(pri_valid), .pri_src(pri_src),
        .fast_req(fast_req), .norm_req(norm_req)
    );

    always_comb begin
        r_d      = r_q;
        clr      = '0;
        r_d.fast = r_q.glb & r_q.hen[0] & fast_req;
        r_d.norm = r_q.glb & r_q.hen[1] & norm_req;
        if (wr_en) begin
            if (wa == A_GLB) r_d.glb = wr_data[0];
            if (wa == A_EN_SET && idx_ok) r_d.en[wr_data[IW-1:0]] = 1'b1;
            if (wa == A_EN_CLR && idx_ok) r_d.en[wr_data[IW-1:0]] = 1'b0;
            if (wa == A_ST_CLR && idx_ok) clr[wr_data[IW-1:0]] = 1'b1;
            if (wa == A_HEN_SET && wr_data < 32'd2) r_d.hen[wr_data[0]] = 1'b1;
            if (wa == A_HEN_CLR && wr_data < 32'd2) r_d.hen[wr_data[0]] = 1'b0;
            if (wa == A_NEST && wr_data[31]) r_d.thr = wr_data[TW-1:0];
            for (int w = 0; w < NWORD; w++) begin
                if (wa == A_STAT + w) clr[w*32 +: 32]     = wr_data;
                if (wa == A_POL + w)  r_d.pol[w*32 +: 32] = wr_data;
                if (wa == A_TYP + w)  r_d.typ[w*32 +: 32] = wr_data;
            end
            for (int m = 0; m < NMAP; m++) begin
                if (wa == A_MAP + m) r_d.chmap[4*m +: 4] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.pol <= '1;
            r_q.thr <= TW'(NUM_CHAN);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (ra == A_GLB)  rd_data = {31'd0, r_q.glb};
        if (ra == A_NEST) rd_data = 32'(r_q.thr);
        if (ra == A_PRI)  rd_data = pri_valid ? 32'(pri_src) : '1;
        for (int w = 0; w < NWORD; w++) begin
            if (ra == A_STAT + w) rd_data = status[w*32 +: 32];
            if (ra == A_POL + w)  rd_data = r_q.pol[w*32 +: 32];
            if (ra == A_TYP + w)  rd_data = r_q.typ[w*32 +: 32];
            if (ra == A_EN + w)   rd_data = r_q.en[w*32 +: 32];
        end
        for (int m = 0; m < NMAP; m++) begin
            if (ra == A_MAP + m) rd_data = r_q.chmap[4*m +: 4];
        end
    end

    assign irq_fast = r_q.fast;
    assign irq_norm = r_q.norm;
endmodule

// File: rtl/ictl_chk.sv
module ictl_chk #(
    parameter int NUM_SRC = 64,
    parameter int IW      = 6,
    parameter int TW      = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               glb,
    input logic [1:0]         hen,
    input logic [TW-1:0]      thr,
    input logic               irq_fast,
    input logic               irq_norm,
    input logic [NUM_SRC-1:0] pend,
    input logic               pri_valid,
    input logic [IW-1:0]      pri_src
);
    a_r7_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glb |=> (!irq_fast && !irq_norm));
    a_r7_fast_host_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !hen[0] |=> !irq_fast);
    a_r7_norm_host_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !hen[1] |=> !irq_norm);
    a_r8_norm_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (thr <= TW'(2)) |=> !irq_norm);
    a_r8_fast_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == '0) |=> !irq_fast);
    a_r9_index_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pri_valid |-> pend[pri_src]);
    a_r10_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> (!irq_fast && !irq_norm));
endmodule

bind ictl_top ictl_chk #(.NUM_SRC(NUM_SRC), .IW(IW), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .glb(r_q.glb), .hen(r_q.hen), .thr(r_q.thr),
    .irq_fast(irq_fast), .irq_norm(irq_norm), .pend(pend),
    .pri_valid(pri_valid), .pri_src(pri_src)
);

// File: tb/ictl_top_test.sv
module ictl_top_test;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_in = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [7:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic          irq_fast, irq_norm;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] smap [NS];

    always #2 clk = ~clk;

    ictl_top #(.NUM_SRC(NS)) uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_fast(irq_fast), .irq_norm(irq_norm)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        rd_addr = 8'(a);
        #1;
        d = rd_data;
    endtask

    task automatic setmap(input int s, input logic [7:0] ch);
        int r;
        r = s / 4;
        smap[s] = ch;
        wr('h40 + r, {smap[4*r+3], smap[4*r+2], smap[4*r+1], smap[4*r]});
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        src_in[s] = 1'b1;
        idle(1);
        src_in[s] = 1'b0;
        idle(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < NS; i++) smap[i] = 8'd0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd('h07, v); chk("R1 index none", v, 32'hFFFF_FFFF);
        rd('h06, v); chk("R1 threshold", v, 32'd32);
        rd('h10, v); chk("R1 polarity", v, 32'hFFFF_FFFF);
        rd('h18, v); chk("R1 mode", v, 32'd0);
        rd('h08, v); chk("R1 status", v, 32'd0);
        rd('h20, v); chk("R1 enable", v, 32'd0);
        rd('h41, v); chk("R1 map", v, 32'd0);
        rd('h00, v); chk("R1 global", v, 32'd0);
        chk("R1 hosts", {30'd0, irq_fast, irq_norm}, 32'd0);

        // R3 enable sweep
        for (int s = 0; s < NS; s++) begin
            wr('h01, s);
            rd('h20 + s / 32, v);
            chk("R3 enable set", v[s % 32], 1'b1);
        end
        wr('h02, 64); wr('h01, 200);
        rd('h21, v); chk("R3 out of range ignored", v, 32'hFFFF_FFFF);
        for (int s = 0; s < NS; s++) wr('h02, s);
        rd('h20, v); chk("R3 enable clear w0", v, 32'd0);
        rd('h21, v); chk("R3 enable clear w1", v, 32'd0);

        // R5 map readback with field order
        wr('h40, 32'h4433_2211);
        rd('h40, v); chk("R5 map readback", v, 32'h4433_2211);
        wr('h40, 32'd0);

        // setup: all edge rising, global and hosts on
        wr('h18, 32'hFFFF_FFFF); wr('h19, 32'hFFFF_FFFF);
        wr('h00, 32'd1); wr('h04, 32'd0); wr('h04, 32'd1);

        // R2 / R10 / R9 / R6 sweep over every source
        for (int s = 0; s < NS; s++) begin
            setmap(s, 8'((s % 30) + 2));
            wr('h01, s);
            @(negedge clk);
            src_in[s] = 1'b1;
            @(negedge clk);
            src_in[s] = 1'b0;
            rd('h08 + s / 32, v); chk("R2 rising edge latch", v[s % 32], 1'b1);
            chk("R10 host not yet", irq_norm, 1'b0);
            @(negedge clk);
            chk("R10 host one clock later", irq_norm, 1'b1);
            chk("R6 fast stays low", irq_fast, 1'b0);
            rd('h07, v); chk("R9 index single", v, s);
            wr('h03, s);
            wr('h02, s);
            idle(1);
            rd('h08 + s / 32, v); chk("R4 index clear", v[s % 32], 1'b0);
            chk("R4 host drops", irq_norm, 1'b0);
        end

        // R2 falling edge on source 5
        wr('h10, ~32'h20);
        wr('h01, 5);
        src_in[5] = 1'b1; idle(2);
        rd('h08, v); chk("R2 falling ignores rise", v[5], 1'b0);
        src_in[5] = 1'b0; idle(2);
        rd('h08, v); chk("R2 falling latches", v[5], 1'b1);
        wr('h03, 5); wr('h02, 5); wr('h10, 32'hFFFF_FFFF);

        // R2 level mode on source 7
        wr('h18, ~32'h80);
        src_in[7] = 1'b1; idle(2);
        rd('h08, v); chk("R2 level follows", v[7], 1'b1);
        wr('h03, 7); idle(1);
        rd('h08, v); chk("R2 level survives clear", v[7], 1'b1);
        src_in[7] = 1'b0; idle(2);
        rd('h08, v); chk("R2 level drops", v[7], 1'b0);
        wr('h10, ~32'h80); idle(1);
        rd('h08, v); chk("R2 active-low level", v[7], 1'b1);
        wr('h10, 32'hFFFF_FFFF); idle(1);
        rd('h08, v); chk("R2 active-low released", v[7], 1'b0);
        wr('h18, 32'hFFFF_FFFF);

        // R4 word clear across words
        pulse(0); pulse(1); pulse(33);
        wr('h08, 32'h0000_0001);
        rd('h08, v); chk("R4 word clear partial", v, 32'h2);
        rd('h09, v); chk("R4 other word kept", v, 32'h2);
        wr('h08, 32'hFFFF_FFFF); wr('h09, 32'hFFFF_FFFF);
        rd('h08, v); chk("R4 word clear w0", v, 32'd0);
        rd('h09, v); chk("R4 word clear w1", v, 32'd0);

        // R8 threshold on source 3, channel 5
        setmap(3, 8'd5); wr('h01, 3); pulse(3); idle(1);
        chk("R8 open threshold", irq_norm, 1'b1);
        wr('h06, 32'h8000_0005); idle(2);
        chk("R8 equal channel blocked", irq_norm, 1'b0);
        wr('h06, 32'h8000_0006); idle(2);
        chk("R8 one above passes", irq_norm, 1'b1);
        wr('h06, 32'h0000_0000); idle(2);
        rd('h06, v); chk("R8 write without bit31 ignored", v, 32'd6);
        chk("R8 still passing", irq_norm, 1'b1);
        setmap(3, 8'd1);
        wr('h06, 32'h8000_0001); idle(2);
        chk("R8 fast blocked at 1", irq_fast, 1'b0);
        wr('h06, 32'h8000_0002); idle(2);
        chk("R8 fast passes at 2", irq_fast, 1'b1);
        wr('h06, 32'h8000_0020);

        // R6 routing and independence
        setmap(3, 8'd0); idle(2);
        chk("R6 ch0 fast", {30'd0, irq_fast, irq_norm}, 32'b10);
        setmap(3, 8'd2); idle(2);
        chk("R6 ch2 normal", {30'd0, irq_fast, irq_norm}, 32'b01);
        setmap(4, 8'd9); setmap(3, 8'd1); wr('h01, 4); pulse(4); idle(1);
        chk("R6 both lines", {30'd0, irq_fast, irq_norm}, 32'b11);

        // R7 gates
        wr('h05, 32'd1); idle(2);
        chk("R7 normal host off", {30'd0, irq_fast, irq_norm}, 32'b10);
        wr('h00, 32'd0); idle(2);
        chk("R7 global off", {30'd0, irq_fast, irq_norm}, 32'b00);
        rd('h07, v); chk("R9 index ignores gates", v, 32'd3);
        wr('h00, 32'd1); wr('h04, 32'd1); idle(2);
        chk("R7 restored", {30'd0, irq_fast, irq_norm}, 32'b11);
        wr('h03, 3); wr('h03, 4); wr('h02, 3); wr('h02, 4);

        // R9 ties and ordering
        setmap(10, 8'd5); setmap(20, 8'd5); setmap(30, 8'd7);
        wr('h01, 10); wr('h01, 20); wr('h01, 30);
        pulse(20); pulse(30);
        rd('h07, v); chk("R9 lower channel wins", v, 32'd20);
        pulse(10);
        rd('h07, v); chk("R9 tie lowest source", v, 32'd10);
        setmap(30, 8'd3);
        rd('h07, v); chk("R9 channel beats number", v, 32'd30);

        // R5 out-of-range channel
        wr('h08, 32'hFFFF_FFFF);
        setmap(30, 8'd40); pulse(30); idle(1);
        rd('h07, v); chk("R5 high channel not indexed", v, 32'hFFFF_FFFF);
        chk("R5 high channel silent", {30'd0, irq_fast, irq_norm}, 32'b00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule